// File: doc/BRIEF.md
# Bipolar Transmit Line Encoder

This block turns one T1 or E1 transmit channel into two pulse rails, one for positive marks and one for negative marks, ready for an analog line driver. Every input is taken on the falling edge of the transmit clock. In single-rail operation one data pin carries NRZ bits. They are encoded as plain alternate mark inversion, or with zero substitution: the eight-zero code used on T1 lines or the four-zero code used on E1 lines. The second pin then serves as a test input. A rising edge on it forces a deliberate bipolar violation onto the next mark. In dual-rail operation the two pins already carry the encoded line and are mapped onto the rails directly.

Dual-rail operation is selected by configuration. A channel in dual-rail operation drops back to single-rail operation by itself when the negative input is held high for too long. This lets a board with no host force a single-rail setup by tying that pin high. The single-rail encoder uses an eight-slot look-ahead window. Its output therefore lags its input by a fixed eight clocks, whatever the code. The dual-rail path has one register.

Top module: `tx_line_encoder`

## Requirements
- R1: While reset is low, both rails are low and `modeSingle` equals the inverse of `cfgDual`. After reset, the single-rail path emits spaces (both rails low) for its first eight clocks.
- R2: In dual-rail operation, the input pair (`dataP`,`dataN`) sampled on a falling edge appears on the rails at that same edge: 00 gives a space, 01 a negative pulse (`lineNeg`=1), 10 a positive pulse (`linePos`=1), and 11 a space. The rails are never both high.
- R3: With `cfgCode`=0, a bit sampled on falling edge k is emitted on falling edge k+8. A one becomes a pulse of the opposite polarity to the previous pulse, and a zero becomes a space. The first pulse after reset is positive.
- R4: With `cfgCode`=1, eight zeros in a row are sent as 000VB0VB. V has the same polarity as the pulse before it and B the opposite polarity. This includes a run that starts right after reset.
- R5: With `cfgCode`=2, four zeros in a row are sent as 000V when an odd number of marks were sent since the last V, and as B00V when the number is even. The count starts even at reset.
- R6: `cfgCode`=3 behaves exactly like `cfgCode`=0.
- R7: In single-rail AMI operation (`cfgCode` 0 or 3), a rising edge on `dataN` turns the next one into a violation that repeats the previous pulse polarity. The mark after it alternates against that same polarity.
- R8: A violation request that arrives while zeros are being sent stays pending and applies to the next one.
- R9: Rising edges on `dataN` have no effect on the rails when `cfgCode` is 1 or 2.
- R10: In dual-rail operation, `modeSingle` rises after `dataN` is sampled high on more than 16 consecutive edges (the parameter `HOLD_CYCLES`). A run of exactly 16 has no effect, and any low sample restarts the count.
- R11: The fallback to single-rail operation is held until `cfgDual` is sampled low. After that, raising `cfgDual` again returns the channel to dual-rail operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit clock; inputs sampled and outputs updated on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDual | input | 1 | 1 selects dual-rail operation |
| cfgCode | input | 2 | Line code in single-rail operation: 0 AMI, 1 eight-zero substitution, 2 four-zero substitution, 3 AMI |
| dataP | input | 1 | NRZ data (single rail) or positive-mark input (dual rail) |
| dataN | input | 1 | Violation request (single rail) or negative-mark input (dual rail) |
| linePos | output | 1 | Positive pulse rail |
| lineNeg | output | 1 | Negative pulse rail |
| modeSingle | output | 1 | 1 while the channel encodes as single rail |

## Verification
Dense mixed ones and zeros, with runs of zeros kept short of any substitution length, check AMI alternation and the eight-clock lag. They also show that code 3 is plain AMI. A long run of zeros straight out of reset, and a run that follows a positive pulse, check both polarity cases of the eight-zero pattern. They also show that the idle fill from reset never triggers a substitution. For the four-zero code, one stream alternates marks with four-zero runs so that both the odd and even cases appear. A second stream of all zeros checks that V polarities alternate over successive substitutions. The same violation stream is sent under AMI and under eight-zero coding. This checks both an immediate and a deferred violation, and shows that violation edges are ignored outside AMI. Directed runs of `dataN` at exactly and just beyond the hold limit bracket the fallback.

// File: rtl/tx_line_encoder_pkg.sv
package tx_line_encoder_pkg;

  localparam int WIN = 8;       // eight-zero substitution spans the whole window
  localparam int HDB_RUN = 4;   // four-zero substitution uses the newest slots

  typedef enum logic [1:0] {
    CODE_AMI     = 2'd0,
    CODE_B8ZS    = 2'd1,
    CODE_HDB3    = 2'd2,
    CODE_AMI_ALT = 2'd3
  } code_e;

  typedef enum logic [2:0] {
    TAG_IDLE,
    TAG_ZERO,
    TAG_ONE,
    TAG_VIOL,
    TAG_BAL
  } tag_e;

  typedef struct packed {
    logic  useSingle;
    logic  tagViol;
    code_e code;
  } ctrl_strobes_t;

endpackage

// File: rtl/tx_line_encoder_ctrl.sv
module tx_line_encoder_ctrl
  import tx_line_encoder_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic          txClk,
  input  logic          rstN,
  input  logic          cfgDual,
  input  logic [1:0]    cfgCode,
  input  logic          dataP,
  input  logic          dataN,
  output ctrl_strobes_t st
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] holdCnt;
  logic          fellBack;
  logic          prevN;
  logic          pending;
  logic          violAllowed;
  logic          violReq;
  code_e         code;

  always_comb begin
    code         = code_e'(cfgCode);
    st.useSingle = !cfgDual || fellBack;
    violAllowed  = st.useSingle && (code == CODE_AMI || code == CODE_AMI_ALT);
    violReq      = violAllowed && ((dataN && !prevN) || pending);
    st.tagViol   = violReq && dataP;
    st.code      = code;
  end

  always_ff @(negedge txClk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      fellBack <= 1'b0;
      prevN    <= 1'b0;
      pending  <= 1'b0;
    end else begin
      prevN   <= dataN;
      pending <= violReq && !dataP;
      if (!cfgDual) begin
        fellBack <= 1'b0;
        holdCnt  <= '0;
      end else if (!fellBack) begin
        if (dataN) begin
          if (holdCnt == CW'(HOLD_CYCLES)) fellBack <= 1'b1;
          else holdCnt <= holdCnt + CW'(1);
        end else begin
          holdCnt <= '0;
        end
      end
    end
  end

  // R10: fallback only follows a held-high negative input in dual-rail operation
  a_r10_fallback_cause: assert property (@(negedge txClk) disable iff (!rstN)
    $rose(fellBack) |-> ($past(cfgDual) && $past(dataN)));

  // R11: deasserting dual-rail configuration clears the fallback
  a_r11_fallback_clear: assert property (@(negedge txClk) disable iff (!rstN)
    !cfgDual |=> !fellBack);

  // R9: a pending violation only exists after AMI single-rail operation
  a_r9_pending_only_ami: assert property (@(negedge txClk) disable iff (!rstN)
    pending |-> $past(violAllowed));

endmodule

// File: rtl/tx_line_encoder_dp.sv
module tx_line_encoder_dp
  import tx_line_encoder_pkg::*;
(
  input  logic          txClk,
  input  logic          rstN,
  input  ctrl_strobes_t st,
  input  logic          dataP,
  input  logic          dataN,
  output logic          linePos,
  output logic          lineNeg
);

  tag_e win [WIN];
  tag_e nxt [WIN];
  tag_e newTag;
  logic parity;
  logic parityNxt;
  logic allZero;
  logic runZero;
  logic lastPol;     // 1: last pulse was positive
  logic pulsePos;
  logic mark;
  logic flip;

  // window update with substitution on the newest slots
  always_comb begin
    newTag = dataP ? (st.tagViol ? TAG_VIOL : TAG_ONE) : TAG_ZERO;
    for (int i = 0; i < WIN - 1; i++) nxt[i] = win[i+1];
    nxt[WIN-1] = newTag;
    allZero = 1'b1;
    for (int i = 0; i < WIN; i++) if (nxt[i] != TAG_ZERO) allZero = 1'b0;
    runZero = 1'b1;
    for (int i = WIN - HDB_RUN; i < WIN; i++) if (nxt[i] != TAG_ZERO) runZero = 1'b0;
    parityNxt = parity;
    if (st.code == CODE_B8ZS && allZero) begin
      nxt[3] = TAG_VIOL;
      nxt[4] = TAG_BAL;
      nxt[6] = TAG_VIOL;
      nxt[7] = TAG_BAL;
    end else if (st.code == CODE_HDB3 && runZero) begin
      if (!parity) nxt[WIN-HDB_RUN] = TAG_BAL;
      nxt[WIN-1] = TAG_VIOL;
      parityNxt  = 1'b0;
    end else if (newTag == TAG_ONE) begin
      parityNxt = !parity;
    end
  end

  // emission of the oldest slot
  always_comb begin
    mark     = 1'b0;
    flip     = 1'b0;
    pulsePos = lastPol;
    case (win[0])
      TAG_ONE, TAG_BAL: begin
        mark     = 1'b1;
        flip     = 1'b1;
        pulsePos = !lastPol;
      end
      TAG_VIOL: mark = 1'b1;
      default:  mark = 1'b0;
    endcase
  end

  always_ff @(negedge txClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN; i++) win[i] <= TAG_IDLE;
      parity  <= 1'b0;
      lastPol <= 1'b0;
      linePos <= 1'b0;
      lineNeg <= 1'b0;
    end else begin
      for (int i = 0; i < WIN; i++) win[i] <= nxt[i];
      parity <= parityNxt;
      if (st.useSingle) begin
        linePos <= mark && pulsePos;
        lineNeg <= mark && !pulsePos;
        if (flip) lastPol <= pulsePos;
      end else begin
        linePos <= dataP && !dataN;
        lineNeg <= dataN && !dataP;
      end
    end
  end

  // R2: rails never drive both polarities
  a_r2_rails_exclusive: assert property (@(negedge txClk) disable iff (!rstN)
    !(linePos && lineNeg));

  // R2: equal dual-rail inputs give a space
  a_r2_dual_space: assert property (@(negedge txClk) disable iff (!rstN)
    (!st.useSingle && dataP == dataN) |=> (!linePos && !lineNeg));

endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
  import tx_line_encoder_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       txClk,
  input  logic       rstN,
  input  logic       cfgDual,
  input  logic [1:0] cfgCode,
  input  logic       dataP,
  input  logic       dataN,
  output logic       linePos,
  output logic       lineNeg,
  output logic       modeSingle
);

  ctrl_strobes_t st;

  tx_line_encoder_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .txClk   (txClk),
    .rstN    (rstN),
    .cfgDual (cfgDual),
    .cfgCode (cfgCode),
    .dataP   (dataP),
    .dataN   (dataN),
    .st      (st)
  );

  tx_line_encoder_dp u_dp (
    .txClk   (txClk),
    .rstN    (rstN),
    .st      (st),
    .dataP   (dataP),
    .dataN   (dataN),
    .linePos (linePos),
    .lineNeg (lineNeg)
  );

  assign modeSingle = st.useSingle;

endmodule

// File: tb/tx_line_encoder_test.sv
module tx_line_encoder_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgDual = 1'b0;
  logic [1:0] cfgCode = 2'd0;
  logic       dataP = 1'b0;
  logic       dataN = 1'b0;
  logic       linePos;
  logic       lineNeg;
  logic       modeSingle;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tx_line_encoder uut (
    .txClk(clk), .rstN(rstN), .cfgDual(cfgDual), .cfgCode(cfgCode),
    .dataP(dataP), .dataN(dataN), .linePos(linePos), .lineNeg(lineNeg),
    .modeSingle(modeSingle)
  );

  typedef struct packed {
    logic [1:0]   code;
    logic [127:0] p;
    logic [127:0] n;
    logic [127:0] e;   // '+' positive, '-' negative, '0' space
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, "1101000110010111", "0000000000000000", "+-0+000-+00-0+-+"},  // R3
    '{2'd3, "1101000110010111", "0000000000000000", "+-0+000-+00-0+-+"},  // R6
    '{2'd1, "1000000001000000", "0000000000000000", "+000+-0-+-000000"},  // R4 after +
    '{2'd1, "0000000000000000", "0000000000000000", "000-+0+-000-+0+-"},  // R4 from reset
    '{2'd2, "1100001000010000", "0000000000000000", "+-+00+-000-+000+"},  // R5 odd/even
    '{2'd2, "0000000000000000", "0000000000000000", "+00+-00-+00+-00-"},  // R5 alternation
    '{2'd0, "1111000110000000", "0011011111111111", "+--+000+-0000000"},  // R7 R8
    '{2'd1, "1111000110000000", "0011011111111111", "+-+-000+-0000000"}   // R9
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    dataP = 1'b0;
    dataN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  function automatic logic [1:0] symOf(input logic [7:0] ch);
    if (ch == "+") return 2'b10;
    if (ch == "-") return 2'b01;
    return 2'b00;
  endfunction

  task automatic runVec(input vec_t v, input string req);
    logic [31:0] got;
    logic [31:0] exp;
    logic        leadBad;
    got = '0;
    exp = '0;
    leadBad = 1'b0;
    cfgDual = 1'b0;
    cfgCode = v.code;
    doReset();
    for (int k = 0; k < 16; k++) exp[2*k +: 2] = symOf(v.e[8*(15-k) +: 8]);
    for (int c = 0; c < 24; c++) begin
      dataP = (c < 16) ? (v.p[8*(15-c) +: 8] == "1") : 1'b1;
      dataN = (c < 16) ? (v.n[8*(15-c) +: 8] == "1") : 1'b0;
      tick();
      if (c < 8) begin
        if (linePos || lineNeg) leadBad = 1'b1;
      end else begin
        got[2*(c-8) +: 2] = {linePos, lineNeg};
      end
    end
    check("R1 idle lead-in", {31'd0, leadBad}, 32'd0);
    check(req, got, exp);
  endtask

  initial begin
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state in both configurations
    rstN = 1'b0;
    cfgDual = 1'b0;
    tick();
    check("R1 rails in reset", {30'd0, linePos, lineNeg}, 32'd0);
    check("R1 mode single", {31'd0, modeSingle}, 32'd1);
    cfgDual = 1'b1;
    #1;
    check("R1 mode dual", {31'd0, modeSingle}, 32'd0);

    // table of encoded streams
    runVec(VECS[0], "R3 AMI stream");
    runVec(VECS[1], "R6 code 3 as AMI");
    runVec(VECS[2], "R4 B8ZS after positive");
    runVec(VECS[3], "R4 B8ZS from reset");
    runVec(VECS[4], "R5 HDB3 parity");
    runVec(VECS[5], "R5 HDB3 zeros");
    runVec(VECS[6], "R7 R8 violation");
    runVec(VECS[7], "R9 violation ignored");

    // R2: dual-rail map
    cfgDual = 1'b1;
    cfgCode = 2'd0;
    doReset();
    dataP = 1'b0; dataN = 1'b0; tick();
    check("R2 00 space", {30'd0, linePos, lineNeg}, 32'b00);
    dataP = 1'b0; dataN = 1'b1; tick();
    check("R2 01 negative", {30'd0, linePos, lineNeg}, 32'b01);
    dataP = 1'b1; dataN = 1'b0; tick();
    check("R2 10 positive", {30'd0, linePos, lineNeg}, 32'b10);
    dataP = 1'b1; dataN = 1'b1; tick();
    check("R2 11 space", {30'd0, linePos, lineNeg}, 32'b00);

    // R10: hold limit
    dataP = 1'b0;
    dataN = 1'b0;
    tick();
    dataN = 1'b1;
    for (int i = 0; i < 16; i++) tick();
    dataN = 1'b0;
    tick();
    check("R10 sixteen highs", {31'd0, modeSingle}, 32'd0);
    dataN = 1'b1;
    for (int i = 0; i < 16; i++) tick();
    check("R10 restarted count", {31'd0, modeSingle}, 32'd0);
    tick();
    check("R10 seventeenth high", {31'd0, modeSingle}, 32'd1);
    tick();
    check("R11 fallback held", {31'd0, modeSingle}, 32'd1);

    // R11: clear through configuration
    cfgDual = 1'b0;
    dataN = 1'b0;
    tick();
    cfgDual = 1'b1;
    #1;
    check("R11 back to dual", {31'd0, modeSingle}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule